// File: doc/BRIEF.md
# Masked Search CAM Core

This block is a small content addressable memory with a fixed number of entries, set by a parameter. Each entry holds one data word and a two-bit occupancy state. A host drives one operation per clock on a synchronous interface made of a valid strobe, an opcode, a mask selector, an address and a data word. With these operations the host loads a search key, loads any of four global mask words, loads a configuration mask, writes entries at an explicit address or at the lowest empty slot, rewrites an entry's state and reads an entry back.

A compare checks the stored key against every entry that is in the Valid state, all in one cycle. The configuration mask is always applied. A global mask is added when the host asks for one. The block then registers three results: a hit flag, a flag for more than one hit, and the index of the lowest-numbered hit. A registered full flag reports that no entry is empty. Writes may be masked by a selected global mask, so that chosen bits of the stored word keep their old value.

Top module: `masked_cam`

## Requirements
- R1: A synchronous active-high reset puts every entry in the Empty state with zero data, clears the key and all mask registers, and drives match_flag, multi_flag, full_flag and match_idx to zero.
- R2: The entry state is coded {skip,empty}: 2'b00 Valid, 2'b01 Empty, 2'b10 Skip, 2'b11 RAM. Only Valid entries can hit in a compare. Opcode 7 loads op_data[1:0] into the state of the entry at op_addr.
- R3: Opcode 2 loads op_data into global mask op_msel. When op_muse is 1, a compare (opcode 4) treats every bit that is 1 in the selected global mask as matching.
- R4: Opcode 3 loads the configuration mask. Its 1 bits count as matching in every compare, whatever op_muse is. It is zero after reset.
- R5: A compare checks the key (loaded by opcode 1) against the Valid entries. One clock edge later, match_idx gives the lowest-numbered hit, or 0 when match_flag is 0.
- R6: multi_flag is 1 after a compare in which two or more entries hit, and 0 otherwise.
- R7: A write (opcode 5 at op_addr, opcode 6 at the free slot) keeps each stored bit whose selected global mask bit is 1 when op_muse is 1, takes op_data elsewhere, and sets the entry to Valid.
- R8: Opcode 6 writes to the lowest-numbered Empty entry. When no entry is Empty it changes nothing.
- R9: Opcode 5 writes at op_addr whether or not the memory is full.
- R10: full_flag is 1 exactly when no entry is Empty. It reflects the entry states two clock edges after the operation that changed them.
- R11: Opcode 8 returns the data and state of the entry at op_addr on rd_data and rd_vstate one edge later.
- R12: match_flag, multi_flag and match_idx keep their values until the next compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Operation code |
| op_msel | input | 2 | Global mask selector |
| op_muse | input | 1 | Apply the selected global mask |
| op_addr | input | $clog2(ENTRIES) | Entry address for explicit write, state set and read |
| op_data | input | WIDTH | Data, key or mask word |
| match_flag | output | 1 | At least one Valid entry hit |
| multi_flag | output | 1 | Two or more entries hit |
| match_idx | output | $clog2(ENTRIES) | Lowest-numbered hit |
| full_flag | output | 1 | No entry is Empty |
| rd_data | output | WIDTH | Read data |
| rd_vstate | output | 2 | Read entry state |

## Verification
The compare results and the read port are registered. Both are due at the first rising edge after the operation is accepted, so the bench drives each operation at a falling edge and samples its result at the next falling edge. The full flag passes through one extra register after the storage update, so after any operation that changes entry states the bench waits one more falling edge before it checks the flag. The compare flags must stay unchanged while writes and register loads run in between. The bench confirms this by sampling them after each such operation.

// File: rtl/cam_pkg.sv
package cam_pkg;

    localparam int NUM_GMASK = 4;
    localparam int MSEL_W    = $clog2(NUM_GMASK);

    typedef enum logic [3:0] {
        OP_NOP     = 4'd0,
        OP_KEY     = 4'd1,
        OP_GMASK   = 4'd2,
        OP_CFGMASK = 4'd3,
        OP_CMP     = 4'd4,
        OP_WR      = 4'd5,
        OP_WRFREE  = 4'd6,
        OP_SETV    = 4'd7,
        OP_RD      = 4'd8
    } cam_op_e;

    typedef enum logic [1:0] {
        VS_VALID = 2'b00,
        VS_EMPTY = 2'b01,
        VS_SKIP  = 2'b10,
        VS_RAM   = 2'b11
    } vstate_e;

    typedef struct packed {
        logic              go;
        cam_op_e           op;
        logic [MSEL_W-1:0] msel;
        logic              muse;
    } cam_ctl_t;

    function automatic logic is_op(cam_ctl_t c, cam_op_e o);
        return c.go && (c.op == o);
    endfunction

endpackage

// File: rtl/cam_regs.sv
module cam_regs
    import cam_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  cam_ctl_t         ctl,
    input  logic [WIDTH-1:0] data,
    output logic [WIDTH-1:0] key,
    output logic [WIDTH-1:0] cmp_mask,
    output logic [WIDTH-1:0] wr_mask
);

    logic [NUM_GMASK-1:0][WIDTH-1:0] gmask;
    logic [WIDTH-1:0]                cfg_mask;
    logic [WIDTH-1:0]                sel_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            key      <= '0;
            cfg_mask <= '0;
            gmask    <= '0;
        end else begin
            if (is_op(ctl, OP_KEY))
                key <= data;
            if (is_op(ctl, OP_CFGMASK))
                cfg_mask <= data;
            if (is_op(ctl, OP_GMASK))
                gmask[ctl.msel] <= data;
        end
    end

    always_comb begin
        sel_mask = ctl.muse ? gmask[ctl.msel] : '0;
        cmp_mask = cfg_mask | sel_mask;
        wr_mask  = sel_mask;
    end

endmodule

// File: rtl/cam_array.sv
module cam_array
    import cam_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int WIDTH   = 64,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [IW-1:0]      wr_addr,
    input  logic [WIDTH-1:0]   wr_data,
    input  logic [WIDTH-1:0]   wr_mask,
    input  logic               setv_en,
    input  logic [IW-1:0]      acc_addr,
    input  vstate_e            setv_val,
    input  logic               rd_en,
    input  logic [WIDTH-1:0]   key,
    input  logic [WIDTH-1:0]   cmp_mask,
    output logic [ENTRIES-1:0] hit_vec,
    output logic [ENTRIES-1:0] empty_vec,
    output logic [WIDTH-1:0]   rd_data,
    output vstate_e            rd_vstate
);

    logic [WIDTH-1:0] mem [ENTRIES];
    vstate_e          vst [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                mem[i] <= '0;
                vst[i] <= VS_EMPTY;
            end
            rd_data   <= '0;
            rd_vstate <= VS_VALID;
        end else begin
            if (setv_en)
                vst[acc_addr] <= setv_val;
            if (wr_en) begin
                mem[wr_addr] <= (mem[wr_addr] & wr_mask) | (wr_data & ~wr_mask);
                vst[wr_addr] <= VS_VALID;
            end
            if (rd_en) begin
                rd_data   <= mem[acc_addr];
                rd_vstate <= vst[acc_addr];
            end
        end
    end

    genvar e;
    generate
        for (e = 0; e < ENTRIES; e++) begin : g_cell
            assign hit_vec[e]   = (vst[e] == VS_VALID) &&
                                  (((mem[e] ^ key) & ~cmp_mask) == '0);
            assign empty_vec[e] = (vst[e] == VS_EMPTY);
        end
    endgenerate

endmodule

// File: rtl/cam_prienc.sv
module cam_prienc #(
    parameter int N   = 32,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic          several,
    output logic [IW-1:0] idx
);

    always_comb begin
        any     = 1'b0;
        several = 1'b0;
        idx     = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                several = several | any;
                any     = 1'b1;
                idx     = IW'(i);
            end
        end
    end

endmodule

// File: rtl/masked_cam.sv
module masked_cam
    import cam_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int WIDTH   = 64,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [1:0]        op_msel,
    input  logic              op_muse,
    input  logic [IW-1:0]     op_addr,
    input  logic [WIDTH-1:0]  op_data,
    output logic              match_flag,
    output logic              multi_flag,
    output logic [IW-1:0]     match_idx,
    output logic              full_flag,
    output logic [WIDTH-1:0]  rd_data,
    output logic [1:0]        rd_vstate
);

    cam_ctl_t           ctl;
    logic [WIDTH-1:0]   key, cmp_mask, wr_mask;
    logic [ENTRIES-1:0] hit_vec, empty_vec;
    logic               hit_any, hit_multi, free_any, free_multi;
    logic [IW-1:0]      hit_idx, free_idx;
    logic               wr_en;
    logic [IW-1:0]      wr_addr;
    vstate_e            rd_vs;

    assign ctl.go   = op_valid;
    assign ctl.op   = cam_op_e'(op_code);
    assign ctl.msel = op_msel;
    assign ctl.muse = op_muse;

    assign wr_en   = is_op(ctl, OP_WR) || (is_op(ctl, OP_WRFREE) && free_any);
    assign wr_addr = (ctl.op == OP_WRFREE) ? free_idx : op_addr;

    cam_regs #(.WIDTH(WIDTH)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .data     (op_data),
        .key      (key),
        .cmp_mask (cmp_mask),
        .wr_mask  (wr_mask)
    );

    cam_array #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_array (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (op_data),
        .wr_mask   (wr_mask),
        .setv_en   (is_op(ctl, OP_SETV)),
        .acc_addr  (op_addr),
        .setv_val  (vstate_e'(op_data[1:0])),
        .rd_en     (is_op(ctl, OP_RD)),
        .key       (key),
        .cmp_mask  (cmp_mask),
        .hit_vec   (hit_vec),
        .empty_vec (empty_vec),
        .rd_data   (rd_data),
        .rd_vstate (rd_vs)
    );

    assign rd_vstate = rd_vs;

    cam_prienc #(.N(ENTRIES)) u_hit_enc (
        .vec     (hit_vec),
        .any     (hit_any),
        .several (hit_multi),
        .idx     (hit_idx)
    );

    cam_prienc #(.N(ENTRIES)) u_free_enc (
        .vec     (empty_vec),
        .any     (free_any),
        .several (free_multi),
        .idx     (free_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            match_flag <= 1'b0;
            multi_flag <= 1'b0;
            match_idx  <= '0;
            full_flag  <= 1'b0;
        end else begin
            full_flag <= ~free_any;
            if (is_op(ctl, OP_CMP)) begin
                match_flag <= hit_any;
                multi_flag <= hit_multi;
                match_idx  <= hit_idx;
            end
        end
    end

    logic unused_ok;
    assign unused_ok = free_multi;

endmodule

// File: rtl/masked_cam_chk.sv
module masked_cam_chk #(
    parameter int ENTRIES = 32,
    localparam int IW     = $clog2(ENTRIES)
) (
    input logic          clk,
    input logic          rst,
    input logic          op_valid,
    input logic [3:0]    op_code,
    input logic          match_flag,
    input logic          multi_flag,
    input logic [IW-1:0] match_idx,
    input logic          full_flag
);

    // R6: more than one hit implies a hit
    a_r6_multi_needs_match: assert property (@(posedge clk) disable iff (rst)
        multi_flag |-> match_flag);

    // R5: index reads zero on a miss
    a_r5_idx_zero_on_miss: assert property (@(posedge clk) disable iff (rst)
        !match_flag |-> (match_idx == '0));

    // R12: compare results hold between compares
    a_r12_results_hold: assert property (@(posedge clk) disable iff (rst)
        !(op_valid && op_code == 4'd4) |=>
            ($stable(match_flag) && $stable(multi_flag) && $stable(match_idx)));

    // R1: reset clears all flags
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!match_flag && !multi_flag && !full_flag && match_idx == '0));

endmodule

bind masked_cam masked_cam_chk #(.ENTRIES(ENTRIES)) u_chk (.*);

// File: tb/sim_masked_cam.sv
module sim_masked_cam;
    import cam_pkg::*;

    localparam int N  = 32;
    localparam int W  = 64;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          op_valid = 1'b0;
    logic [3:0]    op_code = 4'd0;
    logic [1:0]    op_msel = 2'd0;
    logic          op_muse = 1'b0;
    logic [IW-1:0] op_addr = '0;
    logic [W-1:0]  op_data = '0;
    logic          match_flag, multi_flag, full_flag;
    logic [IW-1:0] match_idx;
    logic [W-1:0]  rd_data;
    logic [1:0]    rd_vstate;

    always #10 clk = ~clk;

    masked_cam #(.ENTRIES(N), .WIDTH(W)) u0 (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .op_msel(op_msel), .op_muse(op_muse), .op_addr(op_addr), .op_data(op_data),
        .match_flag(match_flag), .multi_flag(multi_flag), .match_idx(match_idx),
        .full_flag(full_flag), .rd_data(rd_data), .rd_vstate(rd_vstate)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [W-1:0] md [N];
    logic [1:0]   mv [N];
    logic [W-1:0] gm [4];
    logic [W-1:0] cm;
    logic [W-1:0] mkey;

    localparam logic [W-1:0] A = 64'hDEAD_BEEF_0123_4567;
    localparam logic [W-1:0] B = 64'h0F0F_1234_AAAA_5555;
    localparam logic [W-1:0] C = 64'h7777_0000_FFFF_1111;

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input cam_op_e op, input logic [1:0] sel, input logic use_m,
                         input logic [IW-1:0] a, input logic [W-1:0] d);
        op_valid = 1'b1; op_code = op; op_msel = sel; op_muse = use_m;
        op_addr = a; op_data = d;
        @(negedge clk);
        op_valid = 1'b0; op_code = 4'd0; op_muse = 1'b0;
    endtask

    function automatic int first_empty();
        for (int i = 0; i < N; i++) if (mv[i] == 2'b01) return i;
        return -1;
    endfunction

    task automatic ld_key(input logic [W-1:0] d);
        issue(OP_KEY, 2'd0, 1'b0, '0, d); mkey = d;
    endtask
    task automatic ld_gm(input logic [1:0] s, input logic [W-1:0] d);
        issue(OP_GMASK, s, 1'b0, '0, d); gm[s] = d;
    endtask
    task automatic ld_cm(input logic [W-1:0] d);
        issue(OP_CFGMASK, 2'd0, 1'b0, '0, d); cm = d;
    endtask
    task automatic set_v(input int a, input logic [1:0] v);
        issue(OP_SETV, 2'd0, 1'b0, IW'(a), {{(W-2){1'b0}}, v}); mv[a] = v;
    endtask
    task automatic wr_at(input int a, input logic [W-1:0] d, input logic [1:0] s, input logic u);
        logic [W-1:0] m;
        m = u ? gm[s] : '0;
        issue(OP_WR, s, u, IW'(a), d);
        md[a] = (md[a] & m) | (d & ~m); mv[a] = 2'b00;
    endtask
    task automatic wr_free(input logic [W-1:0] d);
        int f;
        f = first_empty();
        issue(OP_WRFREE, 2'd0, 1'b0, '0, d);
        if (f >= 0) begin md[f] = d; mv[f] = 2'b00; end
    endtask

    task automatic cmp(input string tag, input logic [1:0] s, input logic u);
        logic [W-1:0] m;
        int cnt; int first;
        m = cm | (u ? gm[s] : '0);
        cnt = 0; first = 0;
        for (int i = N - 1; i >= 0; i--)
            if (mv[i] == 2'b00 && ((md[i] ^ mkey) & ~m) == '0) begin cnt++; first = i; end
        issue(OP_CMP, s, u, '0, '0);
        chk({tag, " match"}, W'(match_flag), W'(cnt > 0));
        chk({tag, " multi"}, W'(multi_flag), W'(cnt > 1));
        chk({tag, " idx"},   W'(match_idx),  W'(first));
    endtask

    task automatic rd(input string tag, input int a);
        issue(OP_RD, 2'd0, 1'b0, IW'(a), '0);
        chk({tag, " data"},  rd_data,        md[a]);
        chk({tag, " state"}, W'(rd_vstate),  W'(mv[a]));
    endtask

    task automatic chk_full(input string tag);
        @(negedge clk);
        chk(tag, W'(full_flag), W'(first_empty() < 0));
    endtask

    task automatic t_reset();
        chk("R1 match", W'(match_flag), '0);
        chk("R1 multi", W'(multi_flag), '0);
        chk("R1 idx",   W'(match_idx),  '0);
        chk("R1 full",  W'(full_flag),  '0);
        rd("R1 entry0", 0);
        rd("R1 entry31", N - 1);
        ld_key('0);
        cmp("R2 empty entries never hit", 2'd0, 1'b0);
    endtask

    task automatic t_priority();
        ld_key(A);
        wr_at(3, A, 2'd0, 1'b0);
        wr_at(7, A, 2'd0, 1'b0);
        wr_at(9, B, 2'd0, 1'b0);
        cmp("R5 R6 two hits lowest wins", 2'd0, 1'b0);
        ld_key(B);
        cmp("R6 single hit", 2'd0, 1'b0);
        ld_key(C);
        cmp("R5 miss idx zero", 2'd0, 1'b0);
    endtask

    task automatic t_vstate();
        ld_key(A);
        set_v(3, 2'b10);
        cmp("R2 skip entry excluded", 2'd0, 1'b0);
        set_v(7, 2'b11);
        cmp("R2 ram entry excluded", 2'd0, 1'b0);
        rd("R11 skip state readback", 3);
        set_v(3, 2'b00);
        set_v(7, 2'b00);
        cmp("R2 valid again", 2'd0, 1'b0);
    endtask

    task automatic t_gmask();
        ld_gm(2'd2, 64'h0000_0000_0000_00FF);
        ld_key(A ^ 64'h11);
        cmp("R3 no mask misses", 2'd0, 1'b0);
        cmp("R3 global mask 2 hits", 2'd2, 1'b1);
        cmp("R3 zero global mask 1 misses", 2'd1, 1'b1);
    endtask

    task automatic t_cfgmask();
        ld_cm(64'h0000_0000_0000_00F0);
        cmp("R4 partial config mask misses", 2'd0, 1'b0);
        ld_cm(64'h0000_0000_0000_00FF);
        cmp("R4 config mask alone hits", 2'd0, 1'b0);
        ld_gm(2'd1, 64'h0000_0000_0000_000F);
        ld_cm(64'h0000_0000_0000_00F0);
        cmp("R4 config plus global mask hits", 2'd1, 1'b1);
        ld_cm('0);
    endtask

    task automatic t_hold();
        ld_key(A);
        cmp("R12 setup", 2'd0, 1'b0);
        wr_at(12, C, 2'd0, 1'b0);
        chk("R12 after write match", W'(match_flag), W'(1));
        ld_key(C);
        ld_gm(2'd3, '1);
        chk("R12 after loads idx",   W'(match_idx),  W'(3));
        chk("R12 after loads multi", W'(multi_flag), W'(1));
    endtask

    task automatic t_mwrite();
        ld_gm(2'd0, 64'hFFFF_0000_0000_FF00);
        wr_at(9, C, 2'd0, 1'b1);
        rd("R7 masked write merge", 9);
        rd("R7 write sets valid", 12);
        chk("R7 merged value", md[9], 64'h0F0F_0000_FFFF_5511);
    endtask

    task automatic t_full();
        int guard;
        chk_full("R10 not full yet");
        guard = 0;
        while (first_empty() >= 0 && guard < N) begin
            wr_free(64'h1000 + W'(guard));
            guard++;
        end
        chk_full("R10 full after fill");
        rd("R8 first free slot was 0", 0);
        rd("R8 last free slot filled", N - 1);
        ld_key(64'h5A5A_5A5A);
        wr_free(64'h5A5A_5A5A);
        cmp("R8 free write ignored when full", 2'd0, 1'b0);
        chk_full("R8 full unchanged");
        wr_at(0, B ^ C, 2'd0, 1'b0);
        rd("R9 explicit write while full", 0);
        set_v(20, 2'b01);
        chk("R10 not yet updated", W'(full_flag), W'(1));
        chk_full("R10 drops after entry freed");
        wr_free(C ^ A);
        rd("R8 refills freed slot", 20);
        chk_full("R10 full again");
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin md[i] = '0; mv[i] = 2'b01; end
        for (int i = 0; i < 4; i++) gm[i] = '0;
        cm = '0; mkey = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_priority();
        t_vstate();
        t_gmask();
        t_cfgmask();
        t_hold();
        t_mwrite();
        t_full();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule